// File: doc/BRIEF.md
# Stop-Mode Wake-Up and Clock Controller

This controller sits beside a small microcontroller core and runs at the crystal rate. It holds a low-power STOP state and drives the system/timer clock enable while the core runs. A write-only configuration byte sets four things: which port pin or pin group can end STOP, the level that ends it, how long the wake-up reset is held, and how the crystal rate is prescaled into clock enable pulses. Reads return a single sticky status bit. That bit tells firmware whether the last restart came from power-on or from leaving STOP.

Firmware programs the byte and then raises `stop_req`. From then on the controller sends out no clock enables. It watches the selected source through a two-flop synchronizer. When the source reaches the programmed level, or when `ext_rst` is seen, it raises `wake_rst` for a short or long window and then goes back to running. The block has no data stream. All of its pins are plain control and status signals, so no back-pressure rules apply.

Top module: `stopwake_ctrl`

## Requirements
- R1: After `por_n` is released, the configuration is all zero, `cfg_rdata` reads 0x00, `in_stop` and `wake_rst` are low, and `sys_clk_en` pulses once every 2 crystal cycles.
- R2: A cycle with `cfg_wr` high loads `cfg_wdata[6:0]`. The fields are: bit 6 wake level, bit 5 long delay, bits 4:2 source code, bit 1 full-rate clock, bit 0 extra divide-by-16. `cfg_wdata[7]` is ignored. `cfg_rdata` always equals {status bit, 7'b0}.
- R3: The `sys_clk_en` period is 2 cycles when bit 1 is 0 and 1 cycle when bit 1 is 1. Setting bit 0 multiplies the period by 16.
- R4: `stop_req` sampled high while running sets `in_stop` at the next edge. While `in_stop` is high, `sys_clk_en` stays low.
- R5: Source codes are: 001 to 100 select port3 bits 0 to 3, 101 selects port2 bit 7, 110 selects the NOR of port2 bits 3:0, and 111 selects the NOR of port2 bits 7:0. Pins that are not selected do not end STOP.
- R6: Bit 6 = 0 wakes on a low source and bit 6 = 1 wakes on a high source. If a pin reaches the wake level before edge k, `wake_rst` is high from edge k+2.
- R7: With source code 000, no pin activity ends STOP.
- R8: `ext_rst` sampled high during STOP starts the wake sequence under any source code. While running, `ext_rst` has no effect on the outputs.
- R9: `wake_rst` stays high for 64 cycles when bit 5 is 1 and for 2 cycles when bit 5 is 0. After that the block runs again.
- R10: The status bit (`cfg_rdata[7]`) is set on every STOP wake-up. `ext_rst` and writes do not clear it. Only `por_n` clears it.
- R11: Every wake-up clears bit 0 (extra divide-by-16) and keeps bit 1.
- R12: `stop_req` is ignored while `wake_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | External reset request; ends STOP |
| stop_req | input | 1 | Request to enter STOP |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| port3_in | input | 4 | Port 3 pins (asynchronous) |
| port2_in | input | 8 | Port 2 pins (asynchronous) |
| cfg_rdata | output | 8 | Read value: status bit in bit 7, zeros below |
| sys_clk_en | output | 1 | One-cycle system/timer clock enable |
| in_stop | output | 1 | High while in STOP |
| wake_rst | output | 1 | Wake-up reset to the core |

## Verification
The hardest case to reach from the ports is the exact wake edge. A pin change must pass two synchronizer flops and then a source mux that can be a NOR over four or eight pins. The bench sets up each source code with idle pins that hold the source away from its wake level. It then changes only the bits that matter: for the NOR groups it also sets upper bits that must be ignored. It checks that `wake_rst` is still low two edges after the change and high on the third. Two other cases are rare in normal firmware, so the bench forces them on purpose: `ext_rst` as the only way out of STOP under code 000, and a `stop_req` pulse placed inside the 64-cycle wake window.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

  typedef enum logic [1:0] {
    SW_RUN  = 2'd0,
    SW_STOP = 2'd1,
    SW_WAKE = 2'd2
  } sw_state_e;

  // Field order matches the write-data bit positions 6..0
  typedef struct packed {
    logic       lvl_high;   // bit 6
    logic       dly_long;   // bit 5
    logic [2:0] src_sel;    // bits 4:2
    logic       xtal_full;  // bit 1
    logic       pre_div;    // bit 0
  } sw_cfg_t;

  localparam int CFG_W = $bits(sw_cfg_t);

  localparam logic [2:0] SRC_NONE   = 3'b000;
  localparam logic [2:0] SRC_P3_B0  = 3'b001;
  localparam logic [2:0] SRC_P3_B1  = 3'b010;
  localparam logic [2:0] SRC_P3_B2  = 3'b011;
  localparam logic [2:0] SRC_P3_B3  = 3'b100;
  localparam logic [2:0] SRC_P2_B7  = 3'b101;
  localparam logic [2:0] SRC_P2_LO  = 3'b110;
  localparam logic [2:0] SRC_P2_ALL = 3'b111;

endpackage

// File: rtl/swc_cfg_reg.sv
module swc_cfg_reg
  import stopwake_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             wake_i,
  output sw_cfg_t          cfg_o,
  output logic             flag_o
);

  sw_cfg_t cfg_q;
  logic    flag_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) cfg_q <= sw_cfg_t'(wdata_i);
      if (wake_i) begin
        cfg_q.pre_div <= 1'b0;   // wake always drops the extra prescale
        flag_q        <= 1'b1;
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!por_n)
    flag_q |=> flag_q);

  assert_prediv_cleared_R11: assert property (@(posedge clk) disable iff (!por_n)
    wake_i |=> !cfg_q.pre_div);

endmodule

// File: rtl/swc_wake_detect.sv
module swc_wake_detect
  import stopwake_pkg::*;
#(
  parameter int P3_W        = 4,
  parameter int P2_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [P3_W-1:0] p3_i,
  input  logic [P2_W-1:0] p2_i,
  input  logic [2:0]      sel_i,
  input  logic            lvl_i,
  output logic            hit_o
);

  localparam int W = P3_W + P2_W;

  logic [SYNC_STAGES-1:0][W-1:0] stage_q;
  logic [W-1:0]    synced;
  logic [P3_W-1:0] p3s;
  logic [P2_W-1:0] p2s;
  logic            src;

  // Whole pin set is synchronized ahead of the mux, so a selector
  // change never feeds an unsynchronized pin to the level compare.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= {p2_i, p3_i};
      for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign synced = stage_q[SYNC_STAGES-1];
  assign p3s    = synced[P3_W-1:0];
  assign p2s    = synced[W-1:P3_W];

  always_comb begin
    unique case (sel_i)
      SRC_P3_B0:  src = p3s[0];
      SRC_P3_B1:  src = p3s[1];
      SRC_P3_B2:  src = p3s[2];
      SRC_P3_B3:  src = p3s[3];
      SRC_P2_B7:  src = p2s[P2_W-1];
      SRC_P2_LO:  src = ~|p2s[3:0];
      SRC_P2_ALL: src = ~|p2s;
      default:    src = 1'b0;
    endcase
  end

  assign hit_o = (sel_i != SRC_NONE) && (src == lvl_i);

endmodule

// File: rtl/swc_clk_div.sv
module swc_clk_div #(
  parameter int PRE_DIV = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic run_i,
  input  logic full_i,
  input  logic pre_i,
  output logic en_o
);

  localparam int MAXP = 2 * PRE_DIV;
  localparam int CW   = $clog2(MAXP) + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] base;
  logic [CW-1:0] period;
  logic [CW-1:0] last;
  logic          hit_last;

  always_comb begin
    base   = full_i ? CW'(1) : CW'(2);
    period = pre_i ? CW'(base * CW'(PRE_DIV)) : base;
    last   = period - CW'(1);
  end

  // >= so a shortened period after a write wraps at once
  assign hit_last = (cnt_q >= last);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (hit_last)   cnt_q <= '0;
    else                 cnt_q <= cnt_q + CW'(1);
  end

  assign en_o = run_i && hit_last;

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q < CW'(MAXP));

endmodule

// File: rtl/swc_seq.sv
module swc_seq
  import stopwake_pkg::*;
#(
  parameter int LONG_DLY  = 64,
  parameter int SHORT_DLY = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic stop_req_i,
  input  logic ext_rst_i,
  input  logic hit_i,
  input  logic dly_long_i,
  output logic wake_o,
  output logic stopped_o,
  output logic wake_rst_o
);

  localparam int DW = (LONG_DLY > 1) ? $clog2(LONG_DLY) : 1;
  localparam logic [DW-1:0] LONG_LD  = DW'(LONG_DLY - 1);
  localparam logic [DW-1:0] SHORT_LD = DW'(SHORT_DLY - 1);

  sw_state_e     st_q, st_d;
  logic [DW-1:0] dcnt_q;

  always_comb begin
    st_d   = st_q;
    wake_o = 1'b0;
    unique case (st_q)
      SW_RUN:  if (stop_req_i) st_d = SW_STOP;
      SW_STOP: if (ext_rst_i || hit_i) begin
                 st_d   = SW_WAKE;
                 wake_o = 1'b1;
               end
      SW_WAKE: if (dcnt_q == '0) st_d = SW_RUN;
      default: st_d = SW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st_q   <= SW_RUN;
      dcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (wake_o)                                 dcnt_q <= dly_long_i ? LONG_LD : SHORT_LD;
      else if (st_q == SW_WAKE && dcnt_q != '0)   dcnt_q <= dcnt_q - DW'(1);
    end
  end

  assign stopped_o  = (st_q == SW_STOP);
  assign wake_rst_o = (st_q == SW_WAKE);

  assert_stop_entry_R4: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == SW_RUN && stop_req_i) |=> st_q == SW_STOP);

  assert_ext_exit_R8: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == SW_STOP && ext_rst_i) |=> st_q == SW_WAKE);

  assert_window_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == SW_WAKE && dcnt_q != '0) |=> st_q == SW_WAKE);

  assert_no_restop_R12: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == SW_WAKE) |=> st_q != SW_STOP);

endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import stopwake_pkg::*;
#(
  parameter int P3_W        = 4,
  parameter int P2_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_DIV     = 16,
  parameter int LONG_DLY    = 64,
  parameter int SHORT_DLY   = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            ext_rst,
  input  logic            stop_req,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_wdata,
  input  logic [P3_W-1:0] port3_in,
  input  logic [P2_W-1:0] port2_in,
  output logic [7:0]      cfg_rdata,
  output logic            sys_clk_en,
  output logic            in_stop,
  output logic            wake_rst
);

  sw_cfg_t cfg;
  logic    flag;
  logic    wake_pulse;
  logic    hit;

  swc_cfg_reg u_cfg (
    .clk     (clk),
    .por_n   (por_n),
    .wr_i    (cfg_wr),
    .wdata_i (cfg_wdata[CFG_W-1:0]),
    .wake_i  (wake_pulse),
    .cfg_o   (cfg),
    .flag_o  (flag)
  );

  swc_wake_detect #(
    .P3_W        (P3_W),
    .P2_W        (P2_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_det (
    .clk   (clk),
    .por_n (por_n),
    .p3_i  (port3_in),
    .p2_i  (port2_in),
    .sel_i (cfg.src_sel),
    .lvl_i (cfg.lvl_high),
    .hit_o (hit)
  );

  swc_seq #(
    .LONG_DLY  (LONG_DLY),
    .SHORT_DLY (SHORT_DLY)
  ) u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .stop_req_i (stop_req),
    .ext_rst_i  (ext_rst),
    .hit_i      (hit),
    .dly_long_i (cfg.dly_long),
    .wake_o     (wake_pulse),
    .stopped_o  (in_stop),
    .wake_rst_o (wake_rst)
  );

  swc_clk_div #(
    .PRE_DIV (PRE_DIV)
  ) u_div (
    .clk    (clk),
    .por_n  (por_n),
    .run_i  (!in_stop),
    .full_i (cfg.xtal_full),
    .pre_i  (cfg.pre_div),
    .en_o   (sys_clk_en)
  );

  assign cfg_rdata = {flag, 7'b0};

  assert_gated_in_stop_R4: assert property (@(posedge clk) disable iff (!por_n)
    in_stop |-> !sys_clk_en);

  assert_state_excl_R4: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({in_stop, wake_rst}));

  assert_code0_holds_R7: assert property (@(posedge clk) disable iff (!por_n)
    (in_stop && cfg.src_sel == SRC_NONE && !ext_rst) |=> in_stop);

  assert_flag_on_wake_R10: assert property (@(posedge clk) disable iff (!por_n)
    wake_rst |-> cfg_rdata[7]);

endmodule

// File: tb/stopwake_ctrl_bench.sv
module stopwake_ctrl_bench;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst = 1'b0;
  logic       stop_req = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [3:0] port3_in = 4'hF;
  logic [7:0] port2_in = 8'hFF;
  logic [7:0] cfg_rdata;
  logic       sys_clk_en;
  logic       in_stop;
  logic       wake_rst;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stopwake_ctrl u_stopwake_ctrl (
    .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .stop_req(stop_req),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .port3_in(port3_in),
    .port2_in(port2_in), .cfg_rdata(cfg_rdata), .sys_clk_en(sys_clk_en),
    .in_stop(in_stop), .wake_rst(wake_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_st = 0;       // 0 run, 1 stop, 2 wake
  logic [6:0] m_cfg = '0;
  logic       m_flag = 1'b0;
  int         m_div = 0;
  int         m_wc = 0;
  logic [11:0] m_hist [$];    // pin samples, newest at back
  logic       m_hit;
  int         m_ost;
  logic [6:0] m_oc;

  function automatic int period_of(input logic [6:0] c);
    return (c[1] ? 1 : 2) * (c[0] ? 16 : 1);
  endfunction

  function automatic logic hit_of(input logic [6:0] c, input logic [11:0] h);
    logic s;
    case (c[4:2])
      3'd1: s = h[0];
      3'd2: s = h[1];
      3'd3: s = h[2];
      3'd4: s = h[3];
      3'd5: s = h[11];
      3'd6: s = (h[7:4] == 4'h0);
      3'd7: s = (h[11:4] == 8'h00);
      default: s = 1'b0;
    endcase
    return (c[4:2] != 3'd0) && (s == c[6]);
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_st = 0; m_cfg = '0; m_flag = 1'b0; m_div = 0; m_wc = 0;
      m_hist = {12'h0, 12'h0};
    end else begin
      m_ost = m_st;
      m_oc  = m_cfg;
      m_hit = hit_of(m_oc, m_hist[0]);
      if (cfg_wr) m_cfg = cfg_wdata[6:0];
      if (m_ost == 0) begin
        if (stop_req) m_st = 1;
      end else if (m_ost == 1) begin
        if (ext_rst || m_hit) begin
          m_st = 2; m_flag = 1'b1; m_cfg[0] = 1'b0;
          m_wc = m_oc[5] ? 63 : 1;
        end
      end else begin
        if (m_wc == 0) m_st = 0; else m_wc--;
      end
      if (m_ost == 1) m_div = 0;
      else if (m_div >= period_of(m_oc) - 1) m_div = 0;
      else m_div++;
      void'(m_hist.pop_front());
      m_hist.push_back({port2_in, port3_in});
    end
  end

  always @(negedge clk) begin
    if (por_n) begin
      chk("R3 per-cycle sys_clk_en", 32'(sys_clk_en),
          32'((m_st != 1) && (m_div >= period_of(m_cfg) - 1)));
      chk("R4 per-cycle in_stop", 32'(in_stop), 32'(m_st == 1));
      chk("R9 per-cycle wake_rst", 32'(wake_rst), 32'(m_st == 2));
      chk("R10 per-cycle cfg_rdata", 32'(cfg_rdata), 32'({m_flag, 7'b0}));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (sys_clk_en) c++;
    end
  endtask

  task automatic enter_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    chk("R4 in_stop after stop_req", 32'(in_stop), 32'd1);
  endtask

  task automatic wait_wake_end(output int len);
    len = 0;
    while (wake_rst && len < 200) begin
      len++;
      @(negedge clk);
    end
  endtask

  // Program source, stop, release pins, check edge timing and window length
  task automatic wake_test(input logic [2:0] sel, input logic lvl, input logic dly,
                           input logic [3:0] i3, input logic [7:0] i2,
                           input logic [3:0] w3, input logic [7:0] w2);
    int c;
    int len;
    port3_in = i3; port2_in = i2;
    wr({1'b0, lvl, dly, sel, 2'b01});
    tick(4);
    enter_stop();
    count_pulses(8, c);
    chk("R4 no enables in STOP", 32'(c), 32'd0);
    chk("R5 idle pins keep STOP", 32'(in_stop), 32'd1);
    @(negedge clk); port3_in = w3; port2_in = w2;
    tick(2);
    chk("R6 wake not before sync", 32'(wake_rst), 32'd0);
    tick(1);
    chk("R6 wake edge after sync", 32'(wake_rst), 32'd1);
    chk("R10 flag set on wake", 32'(cfg_rdata), 32'h80);
    wait_wake_end(len);
    chk("R9 wake_rst length", 32'(len), dly ? 32'd64 : 32'd2);
    port3_in = i3; port2_in = i2;
    count_pulses(16, c);
    chk("R11 prescale cleared, /2 kept", 32'(c), 32'd8);
  endtask

  initial begin
    int c;
    int len;
    tick(3);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 reset cfg_rdata", 32'(cfg_rdata), 32'h00);
    chk("R1 reset wake_rst", 32'(wake_rst), 32'd0);
    chk("R1 reset in_stop", 32'(in_stop), 32'd0);
    count_pulses(8, c);
    chk("R1 reset rate /2", 32'(c), 32'd4);

    // R2 / R3: write-only fields and prescale rates
    wr(8'hFF);
    chk("R2 bit7 not writable, reads zero", 32'(cfg_rdata), 32'h00);
    wr(8'h03);
    tick(32);
    count_pulses(64, c);
    chk("R3 full rate with /16", 32'(c), 32'd4);
    wr(8'h01);
    tick(32);
    count_pulses(64, c);
    chk("R3 half rate with /16", 32'(c), 32'd2);
    wr(8'h02);
    count_pulses(8, c);
    chk("R3 full rate", 32'(c), 32'd8);

    // R5 / R6 / R9 / R11 across source codes
    wake_test(3'd1, 1'b0, 1'b0, 4'hF, 8'hFF, 4'hE, 8'hFF);
    wake_test(3'd2, 1'b0, 1'b0, 4'hF, 8'h00, 4'hD, 8'h00);
    wake_test(3'd4, 1'b1, 1'b1, 4'h0, 8'h55, 4'h8, 8'h55);
    wake_test(3'd5, 1'b0, 1'b0, 4'h0, 8'hFF, 4'h0, 8'h7F);
    wake_test(3'd6, 1'b1, 1'b0, 4'h5, 8'h01, 4'h5, 8'hF0);
    wake_test(3'd7, 1'b0, 1'b1, 4'hF, 8'h00, 4'hF, 8'h80);
    wake_test(3'd7, 1'b1, 1'b0, 4'h0, 8'h80, 4'h0, 8'h00);

    // R7 / R8: code 000 ignores pins, only ext_rst leaves STOP
    wr(8'h00);
    tick(4);
    enter_stop();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      port3_in = 4'(i); port2_in = 8'(i * 37);
    end
    tick(3);
    chk("R7 code 000 stays in STOP", 32'(in_stop), 32'd1);
    @(negedge clk); ext_rst = 1'b1;
    @(negedge clk); ext_rst = 1'b0;
    chk("R8 ext_rst ends STOP", 32'(wake_rst), 32'd1);
    wait_wake_end(len);
    chk("R9 short window after ext_rst", 32'(len), 32'd2);

    // R8 / R10: ext_rst while running has no effect
    @(negedge clk); ext_rst = 1'b1;
    @(negedge clk); ext_rst = 1'b0;
    tick(1);
    chk("R8 ext_rst in run: wake_rst", 32'(wake_rst), 32'd0);
    chk("R8 ext_rst in run: in_stop", 32'(in_stop), 32'd0);
    chk("R10 flag survives ext_rst", 32'(cfg_rdata), 32'h80);
    wr(8'h00);
    chk("R10 flag survives write", 32'(cfg_rdata), 32'h80);

    // R12: stop_req inside long wake window
    port3_in = 4'hF;
    wr(8'h24);           // long delay, source port3 bit 0, wake low
    tick(4);
    enter_stop();
    @(negedge clk); port3_in = 4'hE;
    tick(3);
    tick(3);
    stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    port3_in = 4'hF;
    wait_wake_end(len);
    chk("R12 stop_req in window ignored", 32'(in_stop), 32'd0);
    tick(2);
    chk("R12 still running", 32'(in_stop), 32'd0);

    // R10: only power-on clears the flag
    @(negedge clk); por_n = 1'b0;
    tick(2);
    por_n = 1'b1;
    @(negedge clk);
    chk("R10 por clears flag", 32'(cfg_rdata), 32'h00);

    tick(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule